// File: doc/BRIEF.md
# Masked-Digit Alarm Comparator

This block holds a set of alarm digit registers for a decimal timekeeper and compares them with the live time digits once per second. There are nine alarm nibbles, one each for seconds, minutes, hours and day-of-month (units and tens), plus one for the day of the week. The tens register of each paired field carries a marker in its top bit. When that marker is set, the whole field is left out of the match. The weekday register carries the same marker for itself. Leaving fields out lets one alarm setting repeat every minute, every hour or every day.

When every field still being compared equals the current time at a one-second tick, a sticky alarm flag is raised. The host reads the flag through a 4-bit banked register bus. It clears the flag and sets the interrupt enable in a single write to the alarm control nibble. The interrupt output is the flag ANDed with the enable. A timer control nibble in a second bank holds only a timer enable bit and a timer flag bit; no countdown is modelled.

Top module: `alarm_digit_matcher`

## Requirements
- R1: After reset every alarm nibble, the alarm flag, the alarm enable and both timer control bits read 0, and `irq` is low.
- R2: A write with `bank`=1 and `addr`=0..8 stores all four bits of `wrData`, and a read of the same location returns them. Nibble order is: 0 seconds units, 1 seconds tens, 2 minutes units, 3 minutes tens, 4 hours units, 5 hours tens, 6 weekday, 7 day units, 8 day tens. A write to `addr` 0..8 with any other bank changes no alarm nibble.
- R3: On a `tick` cycle, the flag is set if every compared field equals `timeNow`. Units nibbles compare all 4 bits. Tens and weekday nibbles compare bits 2:0 only, and bit 3 of the time digit is ignored. Without a `tick`, the flag is never set.
- R4: Bit 3 of alarm nibbles 1, 3, 5 and 8 excludes the whole field (its units and tens) from the match. Bit 3 of nibble 6 excludes the weekday.
- R5: Once set, the flag stays set across later ticks, whether or not they match, and across control writes with bit 1 = 1. It clears only on a control write with bit 1 = 0.
- R6: The alarm control nibble at `bank`=1, `addr`=14 reads bit 0 = enable, bit 1 = flag and bits 3:2 = 0. A write loads the enable from bit 0.
- R7: `irq` is high, as a level, exactly while both the flag and the enable are 1. Clearing either of them drops `irq` on the next cycle.
- R8: The timer control nibble at `bank`=2, `addr`=14 stores `wrData` bits 1:0 (bit 0 timer enable, bit 1 timer flag) and reads them back with bits 3:2 = 0. A write of 0 clears both.
- R9: If a matching `tick` and a flag-clearing control write fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per second, sent once the time digits have settled |
| timeNow | input | 36 | Current time digits; nibble i occupies bits 4i+3:4i, in the same order as the alarm nibbles |
| wrEn | input | 1 | Register write strobe |
| bank | input | 2 | Register bank select |
| addr | input | 4 | Register index within the bank |
| wrData | input | 4 | Write data nibble |
| rdData | output | 4 | Read data nibble for the selected bank and index (combinational) |
| irq | output | 1 | Active-high level interrupt |

## Verification
A corrupted alarm nibble or a broken exclusion marker appears at the ports at the next `tick`. It shows as a flag that is wrongly set or wrongly missing in the control nibble readback, and on `irq` in the same cycle. The bad nibble itself can also be read back at once. Errors in the flag's hold or clear logic show up one cycle after the write or tick that exercises them. The bench therefore samples the flag right after each tick and right after each control write.

// File: rtl/alarm_match_pkg.sv
package alarm_match_pkg;
  localparam int DIGIT_W    = 4;
  localparam int N_ALARM    = 9;
  localparam int ADDR_W     = 4;
  localparam int BANK_W     = 2;
  localparam int CTL_INDEX  = 14;
  localparam int ALARM_BANK = 1;
  localparam int TIMER_BANK = 2;
  localparam int MARK_BIT   = 3;
  localparam int TIME_W     = DIGIT_W * N_ALARM;
  // nibbles that carry an exclusion marker: 1, 3, 5, 6, 8
  localparam logic [N_ALARM-1:0] MARKER_MASK = 9'b101101010;

  typedef struct packed {
    logic [N_ALARM-1:0] wrDigit;
    logic               wrAlmCtl;
    logic               wrTmrCtl;
    logic               cmp;
    logic [DIGIT_W-1:0] data;
    logic [N_ALARM-1:0] rdDigit;
    logic               rdAlmCtl;
    logic               rdTmrCtl;
  } strobe_t;
endpackage

// File: rtl/alarm_match_ctrl.sv
module alarm_match_ctrl
  import alarm_match_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick,
  input  logic                wrEn,
  input  logic [BANK_W-1:0]   bank,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DIGIT_W-1:0]  wrData,
  output strobe_t             st
);
  logic almBank, tmrBank;

  always_comb begin
    almBank = (bank == BANK_W'(ALARM_BANK));
    tmrBank = (bank == BANK_W'(TIMER_BANK));
    st      = '0;
    st.data = wrData;
    st.cmp  = tick;
    for (int i = 0; i < N_ALARM; i++) begin
      st.rdDigit[i] = almBank && (addr == ADDR_W'(i));
      st.wrDigit[i] = wrEn && st.rdDigit[i];
    end
    st.rdAlmCtl = almBank && (addr == ADDR_W'(CTL_INDEX));
    st.rdTmrCtl = tmrBank && (addr == ADDR_W'(CTL_INDEX));
    st.wrAlmCtl = wrEn && st.rdAlmCtl;
    st.wrTmrCtl = wrEn && st.rdTmrCtl;
  end

  // R2: a write reaches at most one register
  a_r2_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.wrDigit, st.wrAlmCtl, st.wrTmrCtl}));
endmodule

// File: rtl/alarm_match_data.sv
module alarm_match_data
  import alarm_match_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            st,
  input  logic [TIME_W-1:0]  timeNow,
  output logic [DIGIT_W-1:0] rdData,
  output logic               almFlag,
  output logic               almEn
);
  logic [DIGIT_W-1:0] almReg [N_ALARM];
  logic [N_ALARM-1:0] fieldEq, fieldSkip;
  logic matchAll, tmrEn, tmrFlag;

  for (genvar i = 0; i < N_ALARM; i++) begin : g_digit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              almReg[i] <= '0;
      else if (st.wrDigit[i]) almReg[i] <= st.data;
    end
    if (MARKER_MASK[i]) begin : g_marked
      assign fieldEq[i]   = almReg[i][MARK_BIT-1:0] ==
                            timeNow[i*DIGIT_W +: MARK_BIT];
      assign fieldSkip[i] = almReg[i][MARK_BIT];
    end else begin : g_units
      assign fieldEq[i]   = almReg[i] == timeNow[i*DIGIT_W +: DIGIT_W];
      assign fieldSkip[i] = almReg[i+1][MARK_BIT];
    end
  end

  assign matchAll = &(fieldEq | fieldSkip);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      almFlag <= 1'b0;
      almEn   <= 1'b0;
      tmrEn   <= 1'b0;
      tmrFlag <= 1'b0;
    end else begin
      if (st.cmp && matchAll)              almFlag <= 1'b1;
      else if (st.wrAlmCtl && !st.data[1]) almFlag <= 1'b0;
      if (st.wrAlmCtl) almEn <= st.data[0];
      if (st.wrTmrCtl) begin
        tmrEn   <= st.data[0];
        tmrFlag <= st.data[1];
      end
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < N_ALARM; i++)
      if (st.rdDigit[i]) rdData = almReg[i];
    if (st.rdAlmCtl) rdData = {2'b00, almFlag, almEn};
    if (st.rdTmrCtl) rdData = {2'b00, tmrFlag, tmrEn};
  end

  // R5: flag holds unless cleared by a control write
  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    almFlag && !(st.wrAlmCtl && !st.data[1]) |=> almFlag);
  // R3: flag rises only after a tick cycle
  a_r3_rise_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(almFlag) |-> $past(st.cmp));
  // R9: matching tick wins over a clearing write
  a_r9_match_wins: assert property (@(posedge clk) disable iff (!rstN)
    st.cmp && matchAll && st.wrAlmCtl |=> almFlag);
  // R8: timer control write of zero clears both bits
  a_r8_timer_clear: assert property (@(posedge clk) disable iff (!rstN)
    st.wrTmrCtl && st.data[1:0] == 2'b00 |=> !tmrEn && !tmrFlag);
endmodule

// File: rtl/alarm_digit_matcher.sv
module alarm_digit_matcher
  import alarm_match_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic [TIME_W-1:0]  timeNow,
  input  logic               wrEn,
  input  logic [BANK_W-1:0]  bank,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DIGIT_W-1:0] wrData,
  output logic [DIGIT_W-1:0] rdData,
  output logic               irq
);
  strobe_t st;
  logic almFlag, almEn;

  alarm_match_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .bank(bank),
    .addr(addr), .wrData(wrData), .st(st)
  );

  alarm_match_data u_data (
    .clk(clk), .rstN(rstN), .st(st), .timeNow(timeNow),
    .rdData(rdData), .almFlag(almFlag), .almEn(almEn)
  );

  assign irq = almFlag & almEn;

  // R7: disabling the interrupt drops irq on the next cycle
  a_r7_irq_drops: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && bank == BANK_W'(ALARM_BANK) && addr == ADDR_W'(CTL_INDEX)
    && !wrData[0] |=> !irq);
endmodule

// File: tb/alarm_digit_matcher_test.sv
`timescale 1ns/1ps
module alarm_digit_matcher_test;
  logic clk = 0, rstN = 0, tick = 0, wrEn = 0;
  logic [35:0] timeNow = '0;
  logic [1:0] bank = '0;
  logic [3:0] addr = '0, wrData = '0, rdData;
  logic irq;
  int nChecks = 0, nFails = 0;
  logic [3:0] v;

  always #2.5 clk = ~clk;

  alarm_digit_matcher uut (
    .clk(clk), .rstN(rstN), .tick(tick), .timeNow(timeNow), .wrEn(wrEn),
    .bank(bank), .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  // {alarm nibbles 8..0, time nibbles 8..0, expected match}
  localparam logic [72:0] VECS [10] = '{
    {36'h253123456, 36'h253123456, 1'b1},
    {36'h253123456, 36'h253123457, 1'b0},
    {36'h2531234D6, 36'h253123400, 1'b1},
    {36'h2531234D6, 36'h253123300, 1'b0},
    {36'h25B123456, 36'h256123456, 1'b1},
    {36'h253123456, 36'h256123456, 1'b0},
    {36'hA5B92B4D6, 36'h000000000, 1'b1},
    {36'h253123456, 36'h153123456, 1'b0},
    {36'h253923456, 36'h253073456, 1'b1},
    {36'h253123456, 36'h2531234D6, 1'b1}
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] b, input logic [3:0] a, input logic [3:0] d);
    @(negedge clk); wrEn = 1; bank = b; addr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(input logic [1:0] b, input logic [3:0] a, output logic [3:0] d);
    @(negedge clk); bank = b; addr = a; #1 d = rdData;
  endtask

  task automatic pulse();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic loadAlarm(input logic [35:0] a);
    for (int i = 0; i < 9; i++) wr(2'd1, 4'(i), a[i*4 +: 4]);
  endtask

  initial begin
    #200000;
    nChecks++; nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    for (int i = 0; i < 9; i++) begin rd(2'd1, 4'(i), v); check("R1 digit", v, 4'h0); end
    rd(2'd1, 4'd14, v); check("R1 alarm ctl", v, 4'h0);
    rd(2'd2, 4'd14, v); check("R8/R1 timer ctl", v, 4'h0);
    check("R1 irq", {3'b0, irq}, 4'h0);

    // R3/R4 vector table
    for (int k = 0; k < 10; k++) begin
      loadAlarm(VECS[k][72:37]);
      wr(2'd1, 4'd14, 4'b0001);
      timeNow = VECS[k][36:1];
      pulse();
      rd(2'd1, 4'd14, v);
      check($sformatf("R3/R4 vec%0d ctl", k), v, {2'b00, VECS[k][0], 1'b1});
      check($sformatf("R7 vec%0d irq", k), {3'b0, irq}, {3'b0, VECS[k][0]});
    end

    // R2 readback and other-bank writes ignored
    loadAlarm(36'h253123456);
    rd(2'd1, 4'd6, v); check("R2 readback wd", v, 4'h3);
    wr(2'd1, 4'd5, 4'hF); rd(2'd1, 4'd5, v); check("R2 full nibble", v, 4'hF);
    wr(2'd1, 4'd5, 4'h1);
    wr(2'd0, 4'd3, 4'h9); wr(2'd3, 4'd3, 4'h7);
    rd(2'd1, 4'd3, v); check("R2 other bank ignored", v, 4'h3);

    // R3 no tick no flag
    wr(2'd1, 4'd14, 4'b0001);
    timeNow = 36'h253123456;
    repeat (4) @(negedge clk);
    rd(2'd1, 4'd14, v); check("R3 no tick", v, 4'b0001);

    // R5 sticky
    pulse();
    timeNow = 36'h000000000;
    pulse();
    rd(2'd1, 4'd14, v); check("R5 sticky over mismatch", v, 4'b0011);
    wr(2'd1, 4'd14, 4'b0011);
    rd(2'd1, 4'd14, v); check("R5 write 1 keeps", v, 4'b0011);
    // R6/R7 enable off with flag kept
    wr(2'd1, 4'd14, 4'b0010);
    rd(2'd1, 4'd14, v); check("R6 enable cleared", v, 4'b0010);
    check("R7 irq off en0", {3'b0, irq}, 4'h0);
    wr(2'd1, 4'd14, 4'b0001);
    rd(2'd1, 4'd14, v); check("R5 cleared", v, 4'b0001);
    wr(2'd1, 4'd14, 4'b1101);
    rd(2'd1, 4'd14, v); check("R6 upper bits read 0", v, 4'b0001);

    // R9 simultaneous tick and clear
    timeNow = 36'h253123456;
    @(negedge clk); tick = 1; wrEn = 1; bank = 2'd1; addr = 4'd14; wrData = 4'b0001;
    @(negedge clk); tick = 0; wrEn = 0;
    rd(2'd1, 4'd14, v); check("R9 match wins", v, 4'b0011);
    check("R7 irq level", {3'b0, irq}, 4'h1);

    // R8 timer control
    wr(2'd2, 4'd14, 4'b1111);
    rd(2'd2, 4'd14, v); check("R8 timer set", v, 4'b0011);
    wr(2'd2, 4'd14, 4'b0000);
    rd(2'd2, 4'd14, v); check("R8 timer clear", v, 4'b0000);
    rd(2'd1, 4'd14, v); check("R8 alarm ctl untouched", v, 4'b0011);

    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule